// File: doc/BRIEF.md
# Fixed-Length Stream Packet Framer

The framer takes a sample stream that can deliver a new word on every clock and cuts it into packets of a programmed length. The packets leave on a 256-bit AXI4-Stream master port that feeds a card-to-host DMA streaming channel. Every beat carries 32 bytes. The length of a transfer is written in bytes through a register-style input. A transfer opens only when the sink re-arms, which the framer sees as a rising edge of TREADY. The beat count is loaded at that moment, so TLAST falls exactly on the boundary that the host asked for. After TLAST the port stays silent until the sink re-arms.

Samples pass through a small FIFO. When the FIFO is full, a sample that arrives is lost, and the loss is recorded in a sticky flag. For bring-up, a select input replaces the FIFO output with an incrementing counter. The counter advances only on accepted beats, so the host can check that the data is continuous across packets.

Top module: `pkt_framer`

## Requirements
- R1: Each beat carries 32 bytes. `m_tkeep_o` is all ones on every valid beat. A beat counts only on a clock where `m_tvalid_o` and `m_tready_i` are both high.
- R2: TLAST is high on beat number `len/32` of a transfer and on no other beat. With the reset length of 1024 bytes, this is beat 32.
- R3: A transfer starts only while the framer is idle, on a clock where `m_tready_i` is high and was low on the previous clock (registered low out of reset). `m_tvalid_o` may rise on the following clock.
- R4: The beat count is taken from the length register at the start. A length written during a transfer, or in the same clock as the start, applies only to the next transfer.
- R5: A transfer ends with exactly one TLAST. After the TLAST beat is accepted, `m_tvalid_o` stays low until the next start.
- R6: While `m_tvalid_o` is high and `m_tready_i` is low, `m_tvalid_o`, `m_tdata_o` and `m_tlast_o` hold their values into the next clock.
- R7: In pattern mode, `m_tdata_o` carries a 32-bit counter in bits 31:0, with the upper bits zero. The counter is 0 after reset, advances by one on each accepted beat only, and keeps running across packets.
- R8: In sample mode, beats carry the FIFO contents in arrival order. `m_tvalid_o` is high during a transfer whenever the FIFO holds a sample.
- R9: A length write whose value is zero or whose bits 4:0 are not zero sets `len_err_o` and leaves the length unchanged. A valid write loads the length and clears `len_err_o`.
- R10: `ovf_o` sets when `smp_valid_i` is high while the FIFO is full. A pop in the same clock does not free space. `ovf_clr_i` clears the flag, but a new overflow in the same clock wins.
- R11: After reset, `m_tvalid_o`, `ovf_o` and `len_err_o` are low, and the length is 1024 bytes.
- R12: The mode select `pat_sel_i` is sampled at the start of a transfer. It holds for that whole transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| smp_valid_i | input | 1 | Sample present on `smp_data_i` |
| smp_data_i | input | 256 | Sample word |
| pat_sel_i | input | 1 | 1 selects the counter pattern, 0 selects the FIFO samples |
| len_we_i | input | 1 | Write strobe for the transfer length |
| len_bytes_i | input | LEN_W | Requested transfer length in bytes |
| len_err_o | output | 1 | Last length write was rejected |
| ovf_clr_i | input | 1 | Synchronous clear of the overflow flag |
| ovf_o | output | 1 | Sticky sample-loss flag |
| m_tdata_o | output | 256 | Stream data |
| m_tkeep_o | output | 32 | Byte qualifiers, always all ones |
| m_tvalid_o | output | 1 | Stream valid |
| m_tlast_o | output | 1 | Last beat of the transfer |
| m_tready_i | input | 1 | Stream ready, and the re-arm signal from the sink |

## Verification
Two events can fall in the same clock. The first is a length write that coincides with the TREADY rising edge that opens a transfer. The bench drives both in one clock and requires the packet to end on the old length, with the new length taking effect on the packet after. The second is an overflow clear that meets a sample arriving at a full FIFO. The bench holds the sample stream on against a stalled sink, pulses the clear, and requires the flag to stay set. Every clock, a queue-based reference model is compared with the ports, and accepted beats are counted against the length loaded at each start.

// File: rtl/framer_pkg.sv
package framer_pkg;
  localparam int unsigned BEAT_BYTES = 32;
  localparam int unsigned BEAT_SHIFT = $clog2(BEAT_BYTES);
  localparam int unsigned DATA_W     = BEAT_BYTES * 8;
  localparam int unsigned KEEP_W     = BEAT_BYTES;

  typedef enum logic {
    SEQ_IDLE = 1'b0,
    SEQ_RUN  = 1'b1
  } seq_state_e;
endpackage

// File: rtl/framer_fifo.sv
module framer_fifo #(
  parameter int unsigned W     = 256,
  parameter int unsigned DEPTH = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic         pop_i,
  input  logic [W-1:0] din_i,
  output logic [W-1:0] dout_o,
  output logic         empty_o,
  output logic         full_o
);
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [W-1:0] mem [DEPTH];
  logic [AW-1:0] wr_q, rd_q;
  logic [AW:0]   cnt_q;

  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == (AW+1)'(DEPTH));
  assign dout_o  = mem[rd_q];

  always_ff @(posedge clk_i) begin
    if (push_i) mem[wr_q] <= din_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push_i) wr_q <= (wr_q == AW'(DEPTH-1)) ? '0 : wr_q + 1'b1;
      if (pop_i)  rd_q <= (rd_q == AW'(DEPTH-1)) ? '0 : rd_q + 1'b1;
      case ({push_i, pop_i})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  AST_FIFO_POP_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> !empty_o); // R8
  AST_FIFO_PUSH_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> !full_o); // R10
endmodule

// File: rtl/framer_len.sv
module framer_len
  import framer_pkg::*;
#(
  parameter int unsigned LEN_W   = 20,
  parameter int unsigned BW      = 15,
  parameter int unsigned DEF_LEN = 1024
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [LEN_W-1:0] bytes_i,
  output logic [BW-1:0]    beats_o,
  output logic             err_o
);
  logic bad_w;
  assign bad_w = (bytes_i == '0) || (bytes_i[BEAT_SHIFT-1:0] != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      beats_o <= BW'(DEF_LEN >> BEAT_SHIFT);
      err_o   <= 1'b0;
    end else if (we_i) begin
      err_o <= bad_w;
      if (!bad_w) beats_o <= bytes_i[LEN_W-1:BEAT_SHIFT];
    end
  end

  AST_LEN_REJECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i && (bytes_i[BEAT_SHIFT-1:0] != '0) |=> err_o && $stable(beats_o)); // R9
  AST_LEN_NONZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    beats_o != '0); // R9
endmodule

// File: rtl/framer_seq.sv
module framer_seq
  import framer_pkg::*;
#(
  parameter int unsigned BW = 15
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tready_i,
  input  logic          pat_sel_i,
  input  logic          fifo_avail_i,
  input  logic [BW-1:0] beats_i,
  output logic          tvalid_o,
  output logic          tlast_o,
  output logic          pat_mode_o,
  output logic          accept_o
);
  seq_state_e    st_q;
  logic [BW-1:0] rem_q;
  logic          rdy_q, pat_q, rise_w;

  assign rise_w     = tready_i & ~rdy_q;
  assign tvalid_o   = (st_q == SEQ_RUN) & (pat_q | fifo_avail_i);
  assign tlast_o    = tvalid_o & (rem_q == BW'(1));
  assign accept_o   = tvalid_o & tready_i;
  assign pat_mode_o = pat_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= SEQ_IDLE;
      rem_q <= '0;
      rdy_q <= 1'b0;
      pat_q <= 1'b0;
    end else begin
      rdy_q <= tready_i;
      unique case (st_q)
        SEQ_IDLE: if (rise_w) begin
          st_q  <= SEQ_RUN;
          rem_q <= beats_i;   // count fixed for the whole transfer
          pat_q <= pat_sel_i;
        end
        SEQ_RUN: if (accept_o) begin
          if (rem_q == BW'(1)) st_q <= SEQ_IDLE;
          else                 rem_q <= rem_q - 1'b1;
        end
        default: st_q <= SEQ_IDLE;
      endcase
    end
  end

  AST_START_ON_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(st_q == SEQ_RUN) |-> $past(tready_i) && !$past(rdy_q)); // R3
  AST_QUIET_AFTER_LAST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tvalid_o && tready_i && tlast_o |=> !tvalid_o); // R5
  AST_STALL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tvalid_o && !tready_i |=> tvalid_o && $stable(tlast_o)); // R6
  AST_MODE_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == SEQ_RUN) && $past(st_q == SEQ_RUN) |-> $stable(pat_q)); // R12
endmodule

// File: rtl/pkt_framer.sv
module pkt_framer
  import framer_pkg::*;
#(
  parameter int unsigned LEN_W      = 20,
  parameter int unsigned DEF_LEN    = 1024,
  parameter int unsigned FIFO_DEPTH = 16,
  parameter int unsigned PAT_W      = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              smp_valid_i,
  input  logic [DATA_W-1:0] smp_data_i,
  input  logic              pat_sel_i,
  input  logic              len_we_i,
  input  logic [LEN_W-1:0]  len_bytes_i,
  output logic              len_err_o,
  input  logic              ovf_clr_i,
  output logic              ovf_o,
  output logic [DATA_W-1:0] m_tdata_o,
  output logic [KEEP_W-1:0] m_tkeep_o,
  output logic              m_tvalid_o,
  output logic              m_tlast_o,
  input  logic              m_tready_i
);
  localparam int unsigned BW = LEN_W - BEAT_SHIFT;

  logic [BW-1:0]     beats_w;
  logic [DATA_W-1:0] fifo_dout_w;
  logic              fifo_empty_w, fifo_full_w, push_w, pop_w;
  logic              accept_w, pat_mode_w;
  logic [PAT_W-1:0]  pat_cnt_q;

  framer_len #(.LEN_W(LEN_W), .BW(BW), .DEF_LEN(DEF_LEN)) u_len (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (len_we_i),
    .bytes_i (len_bytes_i),
    .beats_o (beats_w),
    .err_o   (len_err_o)
  );

  assign push_w = smp_valid_i & ~fifo_full_w;
  assign pop_w  = accept_w & ~pat_mode_w;

  framer_fifo #(.W(DATA_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (push_w),
    .pop_i   (pop_w),
    .din_i   (smp_data_i),
    .dout_o  (fifo_dout_w),
    .empty_o (fifo_empty_w),
    .full_o  (fifo_full_w)
  );

  framer_seq #(.BW(BW)) u_seq (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .tready_i     (m_tready_i),
    .pat_sel_i    (pat_sel_i),
    .fifo_avail_i (~fifo_empty_w),
    .beats_i      (beats_w),
    .tvalid_o     (m_tvalid_o),
    .tlast_o      (m_tlast_o),
    .pat_mode_o   (pat_mode_w),
    .accept_o     (accept_w)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pat_cnt_q <= '0;
      ovf_o     <= 1'b0;
    end else begin
      if (accept_w && pat_mode_w) pat_cnt_q <= pat_cnt_q + 1'b1;
      // a fresh loss beats a clear in the same cycle
      if (smp_valid_i && fifo_full_w) ovf_o <= 1'b1;
      else if (ovf_clr_i)             ovf_o <= 1'b0;
    end
  end

  assign m_tdata_o = pat_mode_w ? DATA_W'(pat_cnt_q) : fifo_dout_w;
  assign m_tkeep_o = '1;

  AST_TDATA_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    m_tvalid_o && !m_tready_i |=> $stable(m_tdata_o)); // R6
  AST_OVF_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_o && !ovf_clr_i |=> ovf_o); // R10
  AST_OVF_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    smp_valid_i && fifo_full_w |=> ovf_o); // R10
  AST_KEEP_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    m_tvalid_o |-> m_tkeep_o == '1); // R1
endmodule

// File: tb/pkt_framer_bench.sv
`timescale 1ns/1ps
module pkt_framer_bench;
  localparam int unsigned DW    = framer_pkg::DATA_W;
  localparam int unsigned KW    = framer_pkg::KEEP_W;
  localparam int unsigned LW    = 16;
  localparam int unsigned DEPTH = 4;
  localparam int unsigned DEFL  = 1024;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic smp_valid = 1'b0;
  logic [DW-1:0] smp_data = '0;
  logic pat_sel = 1'b1;
  logic len_we = 1'b0;
  logic [LW-1:0] len_bytes = '0;
  logic ovf_clr = 1'b0;
  logic tready = 1'b0;
  logic len_err, ovf, tvalid, tlast;
  logic [DW-1:0] tdata;
  logic [KW-1:0] tkeep;

  always #2.5 clk = ~clk;

  pkt_framer #(.LEN_W(LW), .DEF_LEN(DEFL), .FIFO_DEPTH(DEPTH)) u_pkt_framer (
    .clk_i(clk), .rst_ni(rst_n), .smp_valid_i(smp_valid), .smp_data_i(smp_data),
    .pat_sel_i(pat_sel), .len_we_i(len_we), .len_bytes_i(len_bytes),
    .len_err_o(len_err), .ovf_clr_i(ovf_clr), .ovf_o(ovf),
    .m_tdata_o(tdata), .m_tkeep_o(tkeep), .m_tvalid_o(tvalid),
    .m_tlast_o(tlast), .m_tready_i(tready)
  );

  // behavioural reference
  logic [DW-1:0] mq[$];
  bit mrun, mpat, mrdy, movf, merr;
  int mrem, mbeats, mexp;
  logic [31:0] mcnt;
  bit mv, macc, mfull, mrise;

  function automatic bit m_valid();
    return mrun && (mpat || mq.size() > 0);
  endfunction
  function automatic bit m_last();
    return m_valid() && mrem == 1;
  endfunction
  function automatic logic [DW-1:0] m_data();
    if (mpat) return DW'(mcnt);
    return mq[0];
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mq.delete();
      mrun = 0; mpat = 0; mrdy = 0; movf = 0; merr = 0;
      mrem = 0; mbeats = DEFL / 32; mexp = 0; mcnt = 0;
    end else begin
      mv    = m_valid();
      macc  = mv && tready;
      mfull = (mq.size() == DEPTH);
      mrise = tready && !mrdy;
      if (macc && !mpat) void'(mq.pop_front());
      if (smp_valid && !mfull) mq.push_back(smp_data);
      if (smp_valid && mfull) movf = 1;
      else if (ovf_clr) movf = 0;
      if (macc && mpat) mcnt = mcnt + 1;
      if (!mrun) begin
        if (mrise) begin mrun = 1; mrem = mbeats; mexp = mbeats; mpat = pat_sel; end
      end else if (macc) begin
        if (mrem == 1) mrun = 0; else mrem = mrem - 1;
      end
      if (len_we) begin
        if (len_bytes == 0 || len_bytes[4:0] != 0) merr = 1;
        else begin mbeats = int'(len_bytes) / 32; merr = 0; end
      end
      mrdy = tready;
    end
  end

  int total = 0, bad = 0;
  int rdy_mode = 0, sv_mode = 0;
  int beats = 0;
  logic [31:0] smp_cnt = 0;
  bit pv = 0, plast = 0;
  logic [DW-1:0] pd = '0;
  bit done = 0;

  task automatic chk(input bit ok, input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic compare();
    if (pv && tready) begin
      beats++;
      if (plast) begin
        chk(beats == mexp, "R2/R4 beats per packet", DW'(beats), DW'(mexp));
        beats = 0;
      end
    end
    if (pv && !tready)
      chk(tvalid && tdata == pd && tlast == plast, "R6 hold under stall", tdata, pd);
    chk(tvalid == m_valid(), "R3/R5/R8 tvalid", DW'(tvalid), DW'(m_valid()));
    if (tvalid && m_valid()) begin
      chk(tdata == m_data(), "R7/R8/R12 tdata", tdata, m_data());
      chk(tlast == m_last(), "R2 tlast", DW'(tlast), DW'(m_last()));
      chk(tkeep == '1, "R1 tkeep", DW'(tkeep), {KW{1'b1}});
    end
    chk(ovf == movf, "R10 overflow flag", DW'(ovf), DW'(movf));
    chk(len_err == merr, "R9 length error", DW'(len_err), DW'(merr));
    pv = tvalid; plast = tlast; pd = tdata;
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      compare();
      if (rdy_mode != 0) tready = ($urandom % 4) != 0;
      if (sv_mode == 1) smp_valid = 1'b1;
      else if (sv_mode == 2) smp_valid = ($urandom % 3) == 0;
      if (smp_valid) begin smp_cnt++; smp_data = {8{smp_cnt}}; end
    end
  endtask

  task automatic wr_len(input int v);
    len_bytes = LW'(v); len_we = 1'b1;
    tick(1);
    len_we = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    chk(!tvalid && !ovf && !len_err, "R11 reset outputs", {tvalid, ovf, len_err}, '0);
    // R2 default 1024-byte transfer in pattern mode
    tready = 1'b1; tick(40);
    tready = 1'b0; tick(2);
    // R7 pattern across packets under random back-pressure
    wr_len(96); rdy_mode = 1; tick(80); rdy_mode = 0;
    tready = 1'b0; tick(3);
    // R9 rejected lengths, then a valid one
    wr_len(0); tick(1); wr_len(48); tick(1); wr_len(64); tick(1);
    // R4 length write in the same clock as the start
    tready = 1'b1; len_bytes = LW'(32); len_we = 1'b1; tick(1); len_we = 1'b0;
    tick(6); tready = 1'b0; tick(1); tready = 1'b1; tick(6);
    // R4 write during transfer, R12 select change during transfer
    tready = 1'b0; wr_len(160); tready = 1'b1; tick(2);
    wr_len(64); pat_sel = 1'b0; tick(8);
    tready = 1'b0; tick(1); tready = 1'b1; tick(6);
    // R10 overflow under stalled sink, clear colliding with a new loss
    tready = 1'b0; sv_mode = 1; tick(10);
    ovf_clr = 1'b1; tick(1); ovf_clr = 1'b0; tick(2);
    sv_mode = 0; smp_valid = 1'b0; tick(1);
    ovf_clr = 1'b1; tick(1); ovf_clr = 1'b0; tick(2);
    // R8 sample mode, FIFO drains and refills mid transfer
    sv_mode = 2; rdy_mode = 1; tick(200);
    sv_mode = 1; tick(60);
    sv_mode = 0; smp_valid = 1'b0; rdy_mode = 0; tready = 1'b1; tick(20);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule